// File: doc/BRIEF.md
# Time-of-Day Counter with Shadow Readout

This block keeps the time of day as packed BCD hours, minutes and seconds. A one-cycle pulse per second advances it. Internally the count always runs on a 0–23 hour scale. A runtime format input selects how the time is presented: as 24-hour time, or as 12-hour time with a PM flag. A one-cycle add-hour request moves the time forward by one hour, which is how a daylight-saving change is applied. When the hour wraps past midnight, the block raises a one-cycle day-carry pulse for the calendar logic that sits outside it.

The bus reads the time from one of two sources. The first is a shadow copy, refreshed from the live counters once every two clock cycles. The second is the live counters themselves, chosen by a bypass input. An initialization mode freezes the counters and lets the bus load a new time. The loaded value is given in the currently selected format. Counting resumes once the mode is left.

The controller has two states. In `ST_RUN` the counters advance. In `ST_INIT` the counters are frozen and loads are accepted. The transition `ST_RUN -> ST_INIT` is taken when `init_mode` is sampled high. The transition `ST_INIT -> ST_RUN` is taken when `init_mode` is sampled low.

Top module: `rtc_tod_core`

## Requirements
- R1: In `ST_RUN`, a pulse on `add_hour_req` advances the time by exactly one hour and leaves minutes and seconds unchanged. `add_hour_rb` always reads 0.
- R2: Each field holds two BCD digits. Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00.
- R3: Time words are laid out as bit 20 = PM flag, [19:18] hour tens, [17:14] hour units, [13:11] minute tens, [10:7] minute units, [6:4] second tens, [3:0] second units. With `fmt_12h`=0, hours read 00–23 and bit 20 reads 0. With `fmt_12h`=1, hours read 12,01..11 and bit 20 is 1 for afternoon, so the flag toggles when the time passes from 11:59:59 to 12:00:00.
- R4: The hour add wraps correctly. 23 goes to 00, shown in 12-hour mode as 11 PM to 12 AM. In 12-hour mode, 11 AM goes to 12 PM. Every wrap past midnight, whether from a tick or from an add, pulses `day_carry` for exactly one cycle. The pulse appears in the same cycle as the updated time.
- R5: When a tick and an add-hour request arrive in the same cycle, both are applied. The seconds carry is taken first, then the hour is added.
- R6: In `ST_INIT` the counters are frozen. Ticks and add-hour requests are ignored, and `load_en` loads `load_time`, which is interpreted in the current format. After returning to `ST_RUN`, the next tick advances the loaded time.
- R7: With `bypass_shadow`=0, `rd_time` returns the shadow copy. The shadow copy takes the live value every second clock cycle, so `rd_time` may lag `live_time` by up to two cycles.
- R8: With `bypass_shadow`=1, `rd_time` equals `live_time` in every cycle.
- R9: After reset the time is 00:00:00, `day_carry` is 0, and the shadow copy holds the same zero time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| init_mode | input | 1 | Request to freeze the counters for loading |
| load_en | input | 1 | Load `load_time` while in `ST_INIT` |
| load_time | input | 21 | Time to load, in the current display format |
| fmt_12h | input | 1 | 0 = 24-hour, 1 = 12-hour with PM flag |
| add_hour_req | input | 1 | One-cycle request to add one hour |
| bypass_shadow | input | 1 | 1 = read the live counters directly |
| rd_time | output | 21 | Bus read value, from the shadow copy or the live counters |
| live_time | output | 21 | Live counters in display format |
| day_carry | output | 1 | One-cycle pulse when the hour wraps past midnight |
| add_hour_rb | output | 1 | Readback of the add-hour control, always 0 |

## Verification
A tick, an add-hour request or a load sampled at a rising edge changes `live_time` and `day_carry` right after that same edge. A change of `init_mode` takes effect through the state register, so it gates the next edge. The shadow copy picks up a value only on every second edge, so with bypass off the read value trails by one or two edges. The bench runs a behavioural model at each rising edge, using a seconds-of-day integer, a shadow integer and a phase bit. It compares every output at the following falling edge, which is exactly when each of these delays has fully settled.

// File: rtl/rtc_tod_pkg.sv
package rtc_tod_pkg;

    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int HOUR_LAST = 23;
    localparam int HALF_DAY  = 12;

    typedef struct packed {
        logic       pm;
        logic [1:0] hr_t;
        logic [3:0] hr_u;
        logic [2:0] mn_t;
        logic [3:0] mn_u;
        logic [2:0] sc_t;
        logic [3:0] sc_u;
    } tod_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_INIT = 1'b1
    } mode_e;

endpackage

// File: rtl/rtc_tod_step.sv
// Next-time logic: seconds tick first, then the optional hour add.
module rtc_tod_step
    import rtc_tod_pkg::*;
(
    input  tod_t cur,
    input  logic tick,
    input  logic add_hr,
    output tod_t nxt,
    output logic wrap
);
    logic [5:0] s;
    logic [5:0] m;
    logic [4:0] h;

    always_comb begin
        s    = 6'(cur.sc_t) * 6'd10 + 6'(cur.sc_u);
        m    = 6'(cur.mn_t) * 6'd10 + 6'(cur.mn_u);
        h    = 5'(cur.hr_t) * 5'd10 + 5'(cur.hr_u);
        wrap = 1'b0;
        if (tick) begin
            if (s == 6'(SEC_LAST)) begin
                s = '0;
                if (m == 6'(MIN_LAST)) begin
                    m = '0;
                    if (h == 5'(HOUR_LAST)) begin
                        h    = '0;
                        wrap = 1'b1;
                    end else begin
                        h = h + 5'd1;
                    end
                end else begin
                    m = m + 6'd1;
                end
            end else begin
                s = s + 6'd1;
            end
        end
        if (add_hr) begin
            if (h == 5'(HOUR_LAST)) begin
                h    = '0;
                wrap = 1'b1;
            end else begin
                h = h + 5'd1;
            end
        end
        nxt.pm   = 1'b0;
        nxt.hr_t = 2'(h / 5'd10);
        nxt.hr_u = 4'(h % 5'd10);
        nxt.mn_t = 3'(m / 6'd10);
        nxt.mn_u = 4'(m % 6'd10);
        nxt.sc_t = 3'(s / 6'd10);
        nxt.sc_u = 4'(s % 6'd10);
    end
endmodule

// File: rtl/rtc_fmt_out.sv
// Internal 0..23 hour scale to display format.
module rtc_fmt_out
    import rtc_tod_pkg::*;
(
    input  tod_t in24,
    input  logic fmt12,
    output tod_t disp
);
    logic [4:0] h;

    always_comb begin
        disp    = in24;
        disp.pm = 1'b0;
        h       = 5'(in24.hr_t) * 5'd10 + 5'(in24.hr_u);
        if (fmt12) begin
            disp.pm = (h >= 5'(HALF_DAY));
            if (h >= 5'(HALF_DAY)) h = h - 5'(HALF_DAY);
            if (h == 5'd0)         h = 5'(HALF_DAY);
        end
        disp.hr_t = 2'(h / 5'd10);
        disp.hr_u = 4'(h % 5'd10);
    end
endmodule

// File: rtl/rtc_fmt_in.sv
// Display-format load value to internal 0..23 hour scale.
module rtc_fmt_in
    import rtc_tod_pkg::*;
(
    input  tod_t disp,
    input  logic fmt12,
    output tod_t in24
);
    logic [4:0] h;

    always_comb begin
        in24    = disp;
        in24.pm = 1'b0;
        h       = 5'(disp.hr_t) * 5'd10 + 5'(disp.hr_u);
        if (fmt12) begin
            if (h == 5'(HALF_DAY)) h = 5'd0;
            if (disp.pm)           h = h + 5'(HALF_DAY);
        end
        in24.hr_t = 2'(h / 5'd10);
        in24.hr_u = 4'(h % 5'd10);
    end
endmodule

// File: rtl/rtc_tod_core.sv
module rtc_tod_core
    import rtc_tod_pkg::*;
#(
    parameter int SHADOW_PERIOD = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1hz,
    input  logic        init_mode,
    input  logic        load_en,
    input  logic [20:0] load_time,
    input  logic        fmt_12h,
    input  logic        add_hour_req,
    input  logic        bypass_shadow,
    output logic [20:0] rd_time,
    output logic [20:0] live_time,
    output logic        day_carry,
    output logic        add_hour_rb
);
    localparam int CW = (SHADOW_PERIOD > 1) ? $clog2(SHADOW_PERIOD) : 1;

    mode_e          state_q, state_d;
    tod_t           hms_q, shadow_q, step_nxt, load_int, live_disp, shadow_disp;
    logic           step_wrap, day_carry_q, refresh;
    logic [CW-1:0]  cnt_q;

    rtc_tod_step u_step (
        .cur   (hms_q),
        .tick  (tick_1hz),
        .add_hr(add_hour_req),
        .nxt   (step_nxt),
        .wrap  (step_wrap)
    );

    rtc_fmt_in u_fmt_in (
        .disp (tod_t'(load_time)),
        .fmt12(fmt_12h),
        .in24 (load_int)
    );

    rtc_fmt_out u_fmt_live (
        .in24 (hms_q),
        .fmt12(fmt_12h),
        .disp (live_disp)
    );

    rtc_fmt_out u_fmt_shadow (
        .in24 (shadow_q),
        .fmt12(fmt_12h),
        .disp (shadow_disp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (init_mode)  state_d = ST_INIT;
            ST_INIT: if (!init_mode) state_d = ST_RUN;
        endcase
    end

    // Per-state counter actions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hms_q       <= '0;
            day_carry_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    hms_q       <= step_nxt;
                    day_carry_q <= step_wrap;
                end
                ST_INIT: begin
                    if (load_en) hms_q <= load_int;
                    day_carry_q <= 1'b0;
                end
            endcase
        end
    end

    // Shadow refresh every SHADOW_PERIOD cycles
    assign refresh = (cnt_q == CW'(SHADOW_PERIOD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shadow_q <= '0;
        end else begin
            cnt_q <= refresh ? '0 : cnt_q + CW'(1);
            if (refresh) shadow_q <= hms_q;
        end
    end

    assign live_time   = live_disp;
    assign rd_time     = bypass_shadow ? live_disp : shadow_disp;
    assign day_carry   = day_carry_q;
    assign add_hour_rb = 1'b0;

endmodule

// File: rtl/rtc_tod_chk.sv
module rtc_tod_chk
    import rtc_tod_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input mode_e       state_q,
    input logic        load_en,
    input tod_t        hms_q,
    input tod_t        shadow_q,
    input logic        refresh,
    input logic        day_carry,
    input logic        bypass_shadow,
    input logic [20:0] rd_time,
    input logic [20:0] live_time
);
    AST_SEC_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        hms_q.sc_t <= 3'd5 && hms_q.sc_u <= 4'd9 && hms_q.mn_t <= 3'd5 && hms_q.mn_u <= 4'd9); // R2

    AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (5'(hms_q.hr_t) * 5'd10 + 5'(hms_q.hr_u)) <= 5'(HOUR_LAST) && !hms_q.pm); // R2

    AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        day_carry |=> !day_carry); // R4

    AST_CARRY_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        day_carry |-> (hms_q.hr_t == 2'd0 && hms_q.hr_u <= 4'd1)); // R4

    AST_INIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT && !load_en) |=> $stable(hms_q)); // R6

    AST_SHADOW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> shadow_q == $past(hms_q)); // R7

    AST_BYPASS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_shadow |-> rd_time == live_time); // R8
endmodule

bind rtc_tod_core rtc_tod_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .load_en      (load_en),
    .hms_q        (hms_q),
    .shadow_q     (shadow_q),
    .refresh      (refresh),
    .day_carry    (day_carry),
    .bypass_shadow(bypass_shadow),
    .rd_time      (rd_time),
    .live_time    (live_time)
);

// File: tb/tb_rtc_tod_core.sv
`timescale 1ns/1ps
module tb_rtc_tod_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0, init_mode = 1'b0, load_en = 1'b0;
    logic [20:0] load_time = '0;
    logic        fmt_12h = 1'b0, add_hour_req = 1'b0, bypass_shadow = 1'b0;
    logic [20:0] rd_time, live_time;
    logic        day_carry, add_hour_rb;

    int checks = 0, fails = 0;
    bit cmp_on = 1'b0;
    string tag = "R9";

    always #2.5 clk = ~clk;   // 200 MHz

    rtc_tod_core dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .init_mode(init_mode),
        .load_en(load_en), .load_time(load_time), .fmt_12h(fmt_12h),
        .add_hour_req(add_hour_req), .bypass_shadow(bypass_shadow),
        .rd_time(rd_time), .live_time(live_time), .day_carry(day_carry),
        .add_hour_rb(add_hour_rb)
    );

    // ---------------- reference model ----------------
    int m_tod, m_shd, m_nt;
    bit m_ph, m_init, m_carry, m_w;

    function automatic logic [20:0] word(bit pm, int h, int m, int s);
        return {pm, 2'(h / 10), 4'(h % 10), 3'(m / 10), 4'(m % 10), 3'(s / 10), 4'(s % 10)};
    endfunction

    function automatic logic [20:0] disp(int t, bit f12);
        int h = t / 3600;
        bit pm = 1'b0;
        if (f12) begin
            pm = (h >= 12);
            h  = h % 12;
            if (h == 0) h = 12;
        end
        return word(pm, h, (t / 60) % 60, t % 60);
    endfunction

    function automatic int decode(logic [20:0] w, bit f12);
        int h = int'(w[19:18]) * 10 + int'(w[17:14]);
        int m = int'(w[13:11]) * 10 + int'(w[10:7]);
        int s = int'(w[6:4]) * 10 + int'(w[3:0]);
        if (f12) begin
            if (h == 12) h = 0;
            if (w[20]) h = h + 12;
        end
        return h * 3600 + m * 60 + s;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tod = 0; m_shd = 0; m_ph = 0; m_init = 0; m_carry = 0;
        end else begin
            m_nt = m_tod; m_w = 0;
            if (m_ph) m_shd = m_tod;
            m_ph = !m_ph;
            if (!m_init) begin
                if (tick_1hz) begin
                    m_nt++;
                    if (m_nt == 86400) begin m_nt = 0; m_w = 1; end
                end
                if (add_hour_req) begin
                    m_nt += 3600;
                    if (m_nt >= 86400) begin m_nt -= 86400; m_w = 1; end
                end
            end else if (load_en) begin
                m_nt = decode(load_time, fmt_12h);
            end
            m_carry = m_init ? 1'b0 : m_w;
            m_tod   = m_nt;
            m_init  = init_mode;
        end
    end

    task automatic chk(string req, string what, logic [20:0] act, logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) if (cmp_on && rst_n) begin
        chk(tag, "live_time", live_time, disp(m_tod, fmt_12h));
        chk(bypass_shadow ? "R8" : "R7", "rd_time", rd_time,
            bypass_shadow ? disp(m_tod, fmt_12h) : disp(m_shd, fmt_12h));
        chk("R4", "day_carry", 21'(day_carry), 21'(m_carry));
        chk("R1", "add_hour_rb", 21'(add_hour_rb), 21'd0);
    end

    task automatic cyc(bit im, bit ld, logic [20:0] w, bit tk, bit ad);
        @(negedge clk); #1;
        init_mode = im; load_en = ld; load_time = w; tick_1hz = tk; add_hour_req = ad;
    endtask

    task automatic load(logic [20:0] w);
        cyc(1, 0, '0, 0, 0);
        cyc(1, 1, w, 1, 1);     // R6: tick and add ignored in init
        cyc(1, 0, '0, 1, 1);    // R6: frozen
        cyc(0, 0, '0, 0, 0);
        cyc(0, 0, '0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9", "reset live", live_time, '0);
        chk("R9", "reset rd", rd_time, '0);
        chk("R9", "reset carry", 21'(day_carry), '0);
        cmp_on = 1'b1;

        tag = "R2";                        // wraps of seconds and minutes
        for (int i = 0; i < 130; i++) cyc(0, 0, '0, 1, 0);

        tag = "R6";
        load(word(0, 23, 59, 58));
        tag = "R2";                        // into midnight with carry (R4)
        for (int i = 0; i < 4; i++) cyc(0, 0, '0, 1, 0);

        tag = "R1";
        cyc(0, 0, '0, 0, 1);
        cyc(0, 0, '0, 0, 0);
        tag = "R4";
        load(word(0, 23, 10, 5));
        cyc(0, 0, '0, 0, 1);
        cyc(0, 0, '0, 0, 0);

        tag = "R3";
        fmt_12h = 1'b1;
        load(word(0, 11, 59, 59));
        cyc(0, 0, '0, 1, 0);
        cyc(0, 0, '0, 0, 0);
        tag = "R4";
        load(word(0, 11, 20, 0));          // 11 AM -> 12 PM
        cyc(0, 0, '0, 0, 1);
        load(word(1, 11, 30, 0));          // 11 PM -> 12 AM, carry
        cyc(0, 0, '0, 0, 1);
        cyc(0, 0, '0, 0, 0);

        tag = "R5";
        load(word(0, 10, 59, 59));         // tick + add -> 12:00:00 PM
        cyc(0, 0, '0, 1, 1);
        cyc(0, 0, '0, 0, 0);
        fmt_12h = 1'b0;
        load(word(0, 23, 59, 59));         // tick + add -> 01:00:00, carry
        cyc(0, 0, '0, 1, 1);
        cyc(0, 0, '0, 0, 0);

        tag = "R7";
        for (int i = 0; i < 3000; i++) begin
            if (i % 100 == 0) bypass_shadow = ~bypass_shadow;
            if (i % 500 == 250) fmt_12h = ~fmt_12h;
            cyc(0, 0, '0, ($urandom % 3) == 0, ($urandom % 41) == 0);
        end

        cmp_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule